// File: doc/BRIEF.md
# Six-Step Hall Commutator with Drive Protection

This block turns three digitised Hall sensor bits into gate enables for the three half-bridges of a brushless motor. A selectable rotation direction is supported. Each valid Hall state picks one phase to source current (high-side enable) and one phase to sink it (low-side enable). Only the low-side enable is chopped by the PWM bit, so the high side of the active step stays fully on.

Several conditions gate the outputs. A cycle-by-cycle current-limit flag ends the present low-side on-time early. A thermal flag blanks every output for as long as it is asserted. A start/stop input turns the bridge off. A lock guard watches the lock-detect signal from the speed loop. If the motor stays out of lock for a programmable number of clocks while running, the guard latches off the low side until stop is asserted. The guard can be disabled with a dedicated input.

Whenever the applied step changes, through a Hall edge, a direction change or a return from an invalid code, a programmable dead time with all outputs off is inserted. All pins are plain control levels. There is no streamed data, so no valid/ready handshake applies.

Top module: `bldc_commutator`

## Requirements
- R1: With `dir_rev`=0, running, PWM on and no fault, `hall`={IN1,IN2,IN3} (IN1 in bit 2) gives source→sink pairs as follows: 101: phase2→phase1, 100: phase3→phase1, 110: phase3→phase2, 010: phase1→phase2, 011: phase1→phase3, 001: phase2→phase3. Phase n maps to bit n-1 of `hi_en` (source) and `lo_en` (sink).
- R2: With `dir_rev`=1, the step is selected as in R1 using the bitwise complement of `hall`.
- R3: Hall codes 000 and 111 drive all six enables low from the clock after they are sampled.
- R4: When the applied step changes from one valid step to a different one, all enables are low for exactly DEAD_CYC clock cycles before the new step appears. Leaving the all-off state without a pending blank applies the step one clock after it is sampled.
- R5: `pwm_on`=0 forces `lo_en` to 0 at once and leaves `hi_en` unchanged.
- R6: `ilim`=1 forces `lo_en` to 0 at once. The low side then stays off, even after `ilim` falls, until a clock at which `pwm_on` is 0 has been seen.
- R7: `thermal`=1 forces all enables to 0 at once. Once it clears and the blank has run out, the step resumes one clock later.
- R8: `run`=0 forces all enables to 0 at once, and reset leaves them at 0.
- R9: While running, a trip occurs after LOCK_CYC consecutive clocks with `unlocked`=1. Any clock with `unlocked`=0 restarts the count.
- R10: A trip holds `lo_en` at 0, leaves `hi_en` as commanded, and persists regardless of `unlocked` until a clock with `run`=0 clears it.
- R11: With `lock_dis`=1 no trip is ever raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall | input | 3 | Digitised Hall states, IN1 in bit 2, IN3 in bit 0 |
| dir_rev | input | 1 | 1 selects reverse rotation |
| run | input | 1 | 1 = start, 0 = stop |
| pwm_on | input | 1 | PWM on-phase for the low side |
| ilim | input | 1 | Current-limit comparator flag |
| thermal | input | 1 | Over-temperature flag |
| unlocked | input | 1 | 1 while speed is outside the lock window |
| lock_dis | input | 1 | 1 disables the lock guard |
| hi_en | output | 3 | High-side (source) enables, one per phase |
| lo_en | output | 3 | Low-side (sink) enables, one per phase |

## Verification
A wrong applied-step register shows at the ports one clock after the Hall sample, as a wrong source/sink pair or a missing dead-time gap. The bench sweeps all eight codes in both directions to catch it. A stuck current-limit hold or lock trip appears as a low side that stays off after the clearing event. A lock counter that fails to restart or reaches its limit at the wrong count shows as a low-side drop one clock early or late. Both edges of the timeout window are therefore sampled exactly.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
  // step 0 = no drive, 1..6 = commutation steps
  typedef logic [2:0] step_t;

  function automatic step_t code_to_step(input logic [2:0] code);
    case (code)
      3'b101:  return 3'd1;
      3'b100:  return 3'd2;
      3'b110:  return 3'd3;
      3'b010:  return 3'd4;
      3'b011:  return 3'd5;
      3'b001:  return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] step_src(input step_t s);
    case (s)
      3'd1, 3'd6: return 3'b010;
      3'd2, 3'd3: return 3'b100;
      3'd4, 3'd5: return 3'b001;
      default:    return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] step_snk(input step_t s);
    case (s)
      3'd1, 3'd2: return 3'b001;
      3'd3, 3'd4: return 3'b010;
      3'd5, 3'd6: return 3'b100;
      default:    return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/hall_step_map.sv
module hall_step_map
  import bldc_pkg::*;
(
  input  logic [2:0] hall,
  input  logic       dir_rev,
  output step_t      step
);
  logic [2:0] code;
  // reverse reuses the forward table with complemented sensor bits
  assign code = dir_rev ? ~hall : hall;
  assign step = code_to_step(code);
endmodule

// File: rtl/step_blanker.sv
module step_blanker
  import bldc_pkg::*;
#(
  parameter int DEAD_CYC = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  step_t want,
  output step_t act
);
  localparam int DT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC);
  localparam logic [DT_W-1:0] DT_LOAD = DT_W'(DEAD_CYC - 1);

  step_t           act_q;
  logic [DT_W-1:0] dt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= '0;
      dt_q  <= '0;
    end else if (act_q != 3'd0 && want != act_q) begin
      act_q <= '0;
      dt_q  <= DT_LOAD;
    end else if (act_q == 3'd0) begin
      if (dt_q != '0)        dt_q  <= dt_q - 1'b1;
      else if (want != 3'd0) act_q <= want;
    end
  end

  assign act = act_q;

  // R4
  property no_direct_swap;
    @(posedge clk) disable iff (!rst_n)
      (act_q != 3'd0) |=> (act_q == $past(act_q) || act_q == 3'd0);
  endproperty
  no_direct_swap_chk: assert property (no_direct_swap);

  // R4
  property hold_blank;
    @(posedge clk) disable iff (!rst_n)
      (act_q == 3'd0 && dt_q != '0) |=> (act_q == 3'd0);
  endproperty
  hold_blank_chk: assert property (hold_blank);
endmodule

// File: rtl/lock_guard.sv
module lock_guard #(
  parameter int LOCK_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic unlocked,
  input  logic dis,
  output logic trip
);
  localparam int LK_W = (LOCK_CYC < 2) ? 1 : $clog2(LOCK_CYC);
  localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_CYC - 1);

  logic [LK_W-1:0] cnt_q;
  logic            trip_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (dis || !unlocked) begin
      cnt_q <= '0;
    end else if (!trip_q) begin
      if (cnt_q == LK_LAST) begin
        trip_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign trip = trip_q;

  // R10
  property trip_sticky;
    @(posedge clk) disable iff (!rst_n) (trip_q && run) |=> trip_q;
  endproperty
  trip_sticky_chk: assert property (trip_sticky);

  // R9
  property cnt_in_range;
    @(posedge clk) disable iff (!rst_n) (cnt_q <= LK_LAST);
  endproperty
  cnt_in_range_chk: assert property (cnt_in_range);

  // R11
  property no_trip_when_dis;
    @(posedge clk) disable iff (!rst_n) (dis && !trip_q) |=> !trip_q;
  endproperty
  no_trip_when_dis_chk: assert property (no_trip_when_dis);
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_pkg::*;
#(
  parameter int DEAD_CYC = 4,
  parameter int LOCK_CYC = 1000,
  parameter int PHASES   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        hall,
  input  logic              dir_rev,
  input  logic              run,
  input  logic              pwm_on,
  input  logic              ilim,
  input  logic              thermal,
  input  logic              unlocked,
  input  logic              lock_dis,
  output logic [PHASES-1:0] hi_en,
  output logic [PHASES-1:0] lo_en
);
  step_t map_step, want_step, act_step;
  logic  trip, ilim_hold_q;
  logic  allow_hi, allow_lo;
  logic [2:0] src_vec, snk_vec;

  hall_step_map u_map (
    .hall    (hall),
    .dir_rev (dir_rev),
    .step    (map_step)
  );

  assign allow_hi  = run & ~thermal;
  assign want_step = allow_hi ? map_step : 3'd0;

  step_blanker #(.DEAD_CYC(DEAD_CYC)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .want  (want_step),
    .act   (act_step)
  );

  lock_guard #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .unlocked (unlocked),
    .dis      (lock_dis),
    .trip     (trip)
  );

  // current-limit hold: ends the present on-time, rearmed by PWM off-phase
  always_ff @(posedge clk) begin
    if (!rst_n) ilim_hold_q <= 1'b0;
    else        ilim_hold_q <= ilim | (ilim_hold_q & pwm_on);
  end

  assign allow_lo = allow_hi & pwm_on & ~ilim & ~ilim_hold_q & ~trip;
  assign src_vec  = step_src(act_step);
  assign snk_vec  = step_snk(act_step);

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    assign hi_en[p] = allow_hi & src_vec[p];
    assign lo_en[p] = allow_lo & snk_vec[p];
  end

  // R1
  property no_shoot;
    @(posedge clk) disable iff (!rst_n)
      ((hi_en & lo_en) == '0) && $onehot0(hi_en) && $onehot0(lo_en);
  endproperty
  no_shoot_chk: assert property (no_shoot);

  // R3
  property bad_code_off;
    @(posedge clk) disable iff (!rst_n)
      (hall == 3'b000 || hall == 3'b111) |=> (act_step == 3'd0);
  endproperty
  bad_code_off_chk: assert property (bad_code_off);

  // R5
  property pwm_low_only;
    @(posedge clk) disable iff (!rst_n) !pwm_on |-> (lo_en == '0);
  endproperty
  pwm_low_only_chk: assert property (pwm_low_only);

  // R6
  property ilim_cut;
    @(posedge clk) disable iff (!rst_n)
      ilim |=> (!pwm_on || lo_en == '0);
  endproperty
  ilim_cut_chk: assert property (ilim_cut);

  // R7
  property stop_or_hot_off;
    @(posedge clk) disable iff (!rst_n)
      (!run || thermal) |-> (hi_en == '0 && lo_en == '0);
  endproperty
  stop_or_hot_off_chk: assert property (stop_or_hot_off);

  // R10
  property trip_low_off;
    @(posedge clk) disable iff (!rst_n) trip |-> (lo_en == '0);
  endproperty
  trip_low_off_chk: assert property (trip_low_off);
endmodule

// File: tb/test_bldc_commutator.sv
module test_bldc_commutator;
  localparam int D = 3;
  localparam int L = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall = 3'b000;
  logic dir_rev = 1'b0, run = 1'b0, pwm_on = 1'b0, ilim = 1'b0;
  logic thermal = 1'b0, unlocked = 1'b0, lock_dis = 1'b0;
  logic [2:0] hi_en, lo_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bldc_commutator #(.DEAD_CYC(D), .LOCK_CYC(L)) i_bldc_commutator (
    .clk(clk), .rst_n(rst_n), .hall(hall), .dir_rev(dir_rev), .run(run),
    .pwm_on(pwm_on), .ilim(ilim), .thermal(thermal), .unlocked(unlocked),
    .lock_dis(lock_dis), .hi_en(hi_en), .lo_en(lo_en)
  );

  // expected {hi,lo} from R1/R2: forward step order with source/sink phase numbers
  function automatic logic [5:0] model(input logic d, input logic [2:0] h);
    logic [2:0] c;
    logic [2:0] seq [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};
    int src [6] = '{2, 3, 3, 1, 1, 2};
    int snk [6] = '{1, 1, 2, 2, 3, 3};
    c = d ? ~h : h;
    for (int k = 0; k < 6; k++)
      if (seq[k] == c) return {3'(1 << (src[k] - 1)), 3'(1 << (snk[k] - 1))};
    return 6'b0;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input logic [5:0] exp);
    checks++;
    if ({hi_en, lo_en} !== exp) begin
      errors++;
      $display("FAIL %s: got hi=%b lo=%b, expected hi=%b lo=%b",
               req, hi_en, lo_en, exp[5:3], exp[2:0]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    check("R8 reset", 6'b0);
    rst_n = 1'b1; tick(1);
    check("R8 stopped", 6'b0);
    run = 1'b1; pwm_on = 1'b1;

    // R1 / R2 / R3 sweep over every code in both directions
    for (int d = 0; d < 2; d++) begin
      for (int h = 0; h < 8; h++) begin
        dir_rev = d[0]; hall = h[2:0];
        tick(D + 2);
        check(d ? "R2/R3 sweep" : "R1/R3 sweep", model(d[0], h[2:0]));
      end
    end

    // R4 dead time on Hall edge
    dir_rev = 1'b0; hall = 3'b101; tick(D + 2);
    check("R4 start", model(1'b0, 3'b101));
    hall = 3'b100; tick(1);
    check("R4 blank first", 6'b0);
    tick(D - 1);
    check("R4 blank last", 6'b0);
    tick(1);
    check("R4 new step", model(1'b0, 3'b100));
    // R4 dead time on direction change
    dir_rev = 1'b1; tick(1);
    check("R4 dir blank first", 6'b0);
    tick(D - 1);
    check("R4 dir blank last", 6'b0);
    tick(1);
    check("R4 dir new step", model(1'b1, 3'b100));
    dir_rev = 1'b0; tick(D + 2);

    // R5 PWM chops low side only
    pwm_on = 1'b0; #1;
    check("R5 pwm off", {model(1'b0, 3'b100)[5:3], 3'b0});
    pwm_on = 1'b1; #1;
    check("R5 pwm on", model(1'b0, 3'b100));

    // R6 current limit with hold
    ilim = 1'b1; #1;
    check("R6 cut", {model(1'b0, 3'b100)[5:3], 3'b0});
    tick(1); ilim = 1'b0; #1;
    check("R6 hold", {model(1'b0, 3'b100)[5:3], 3'b0});
    pwm_on = 1'b0; tick(1); pwm_on = 1'b1; #1;
    check("R6 rearm", model(1'b0, 3'b100));

    // R7 thermal
    thermal = 1'b1; #1;
    check("R7 hot now", 6'b0);
    tick(10);
    check("R7 hot held", 6'b0);
    thermal = 1'b0; tick(1);
    check("R7 resume", model(1'b0, 3'b100));

    // R9 timeout window and restart
    unlocked = 1'b1; tick(L - 1);
    check("R9 before limit", model(1'b0, 3'b100));
    unlocked = 1'b0; tick(1);
    unlocked = 1'b1; tick(L - 1);
    check("R9 restarted", model(1'b0, 3'b100));
    tick(1);
    check("R9/R10 trip", {model(1'b0, 3'b100)[5:3], 3'b0});
    // R10 latched
    unlocked = 1'b0; tick(3);
    check("R10 latched", {model(1'b0, 3'b100)[5:3], 3'b0});
    run = 1'b0; #1;
    check("R8 stop", 6'b0);
    tick(1); run = 1'b1; tick(D + 1);
    check("R10 cleared by stop", model(1'b0, 3'b100));

    // R11 disable
    lock_dis = 1'b1; unlocked = 1'b1; tick(L + 5);
    check("R11 disabled", model(1'b0, 3'b100));
    lock_dis = 1'b0; tick(L);
    check("R9 re-enabled trip", {model(1'b0, 3'b100)[5:3], 3'b0});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule